// File: doc/BRIEF.md
# Virtual Address Region Translator

This block turns one 32-bit virtual address into a physical address for a single load, store or instruction fetch. Each request carries an access kind, a user-mode flag and an 8-bit process tag. The top three address bits pick one of four fixed regions. Two of these regions map straight through to physical memory. The other two go through a 16-entry fully associative translation table. A table lookup matches on the process tag together with the virtual page number.

The result appears one clock after the request. It carries a physical address, a cacheable flag and a two-bit exception code. An exception reports a user-mode violation, a table miss or a missing permission. Software refills the table through a write port that takes an entry index and the full entry contents. Pages are 4 KB, so address bits 31:12 form the page number and bits 11:0 the page offset.

Top module: `mmu_region_xlate`

## Requirements
- R1: After reset every table entry is invalid and `rsp_valid` is 0. A translated access made before any table write returns exception code 2.
- R2: `rsp_valid` equals `req_valid` from the previous clock. While `rsp_valid` is 0, `rsp_paddr`, `rsp_exc` and `rsp_cacheable` are all 0.
- R3: A supervisor access with address bits 31:29 = 3'b111 bypasses the table. It returns code 0, the low 29 address bits zero-extended as `rsp_paddr`, and `rsp_cacheable` = 0.
- R4: A supervisor access with address bits 31:29 = 3'b110 bypasses the table. It returns code 0, the low 29 address bits zero-extended as `rsp_paddr`, and `rsp_cacheable` = 1.
- R5: A user-mode access (`req_user` = 1) with address bit 31 set returns exception code 1. A user-mode access with bit 31 clear never returns code 1.
- R6: A table hit needs the entry to be valid, its tag to equal `req_pid` and its page number to equal address bits 31:12. On a hit `rsp_paddr` is {frame number, address bits 11:0}, and `rsp_cacheable` is the entry's cacheable bit.
- R7: A translated access with no hit returns exception code 2, and `rsp_paddr` is 0.
- R8: The access kind codes are 0 = load, 1 = store, 2 = fetch, and 3 is handled as a fetch. A load needs the entry's read bit, a store its write bit and a fetch its execute bit. A hit whose needed bit is 0 returns code 3.
- R9: When several exceptions apply, the code reported is the highest in priority: mode (1), then miss (2), then permission (3). Any nonzero code forces both `rsp_paddr` and `rsp_cacheable` to 0.
- R10: When `wr_en` is 1, entry `wr_idx` takes all the `wr_*` fields at the clock edge. A request in the same cycle is looked up against the contents from before that write.
- R11: When more than one entry hits, the entry with the lowest index supplies the frame number and the attributes.
- R12: A supervisor access with address bits 31:30 = 2'b10 goes through the table, following R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 treated as fetch |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_pid | input | 8 | Process tag |
| wr_en | input | 1 | Table entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the entry |
| wr_pid | input | 8 | Process tag for the entry |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_pfn | input | 20 | Physical frame number for the entry |
| wr_rd | input | 1 | Read permission |
| wr_wr | input | 1 | Write permission |
| wr_ex | input | 1 | Execute permission |
| wr_cache | input | 1 | Cacheable attribute |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, 0 on an exception |
| rsp_cacheable | output | 1 | Cacheable flag, 0 on an exception |
| rsp_exc | output | 2 | 0 none, 1 mode, 2 miss, 3 permission |

## Verification
The assertions compare each response with the request from one cycle earlier. They therefore assume that `req_valid` stays low while reset is active, and that the request fields are held at known values whenever `req_valid` is 1. The stimulus drives every input at the falling edge and holds `req_valid` at 0 for the whole reset. It never lets a request field be unknown. It also never overlaps a write with a request, except in the one test that checks R10 on purpose.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      EXC_NONE = 2'd0,
      EXC_MODE = 2'd1,
      EXC_MISS = 2'd2,
      EXC_PERM = 2'd3
   } exc_code_e;

   typedef enum logic [1:0] {
      RG_USER    = 2'd0,
      RG_KMAPPED = 2'd1,
      RG_KDIRECT = 2'd2,
      RG_IODIRECT = 2'd3
   } region_e;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
      logic cache;
   } page_attr_t;

   typedef struct packed {
      region_e kind;
      logic    bypass;
      logic    user_ok;
      logic    fixed_cache;
   } region_info_t;

endpackage

// File: rtl/mmu_region_decode.sv
module mmu_region_decode
   import mmu_xlate_pkg::*;
(
   input  logic [2:0]   top_bits,
   output region_info_t info
);

   always_comb begin
      info = '0;
      unique casez (top_bits)
         3'b0??: begin
            info.kind        = RG_USER;
            info.bypass      = 1'b0;
            info.user_ok     = 1'b1;
            info.fixed_cache = 1'b0;
         end
         3'b10?: begin
            info.kind        = RG_KMAPPED;
            info.bypass      = 1'b0;
            info.user_ok     = 1'b0;
            info.fixed_cache = 1'b0;
         end
         3'b110: begin
            info.kind        = RG_KDIRECT;
            info.bypass      = 1'b1;
            info.user_ok     = 1'b0;
            info.fixed_cache = 1'b1;
         end
         default: begin
            info.kind        = RG_IODIRECT;
            info.bypass      = 1'b1;
            info.user_ok     = 1'b0;
            info.fixed_cache = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/mmu_tlb_cam.sv
module mmu_tlb_cam
   import mmu_xlate_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PID_W   = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [PID_W-1:0] wr_pid,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PFN_W-1:0] wr_pfn,
   input  page_attr_t       wr_attr,
   input  logic [PID_W-1:0] lk_pid,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PFN_W-1:0] lk_pfn,
   output page_attr_t       lk_attr
);

   logic [ENTRIES-1:0] ent_valid;
   logic [PID_W-1:0]   ent_pid  [ENTRIES];
   logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
   logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
   page_attr_t         ent_attr [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [IDX_W-1:0]   sel;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_valid[g] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            ent_valid[g] <= wr_valid;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IDX_W'(g))) begin
            ent_pid[g]  <= wr_pid;
            ent_vpn[g]  <= wr_vpn;
            ent_pfn[g]  <= wr_pfn;
            ent_attr[g] <= wr_attr;
         end
      end

      assign match[g] = ent_valid[g] && (ent_pid[g] == lk_pid) && (ent_vpn[g] == lk_vpn);
   end

   always_comb begin
      sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) sel = IDX_W'(i);
      end
   end

   assign lk_hit  = |match;
   assign lk_pfn  = ent_pfn[sel];
   assign lk_attr = ent_attr[sel];

endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
   import mmu_xlate_pkg::*;
(
   input  region_info_t rinfo,
   input  logic         user,
   input  logic [1:0]   kind,
   input  logic         hit,
   input  page_attr_t   attr,
   output exc_code_e    exc,
   output logic         cacheable
);

   logic allowed;

   always_comb begin
      unique case (acc_kind_e'(kind))
         ACC_LOAD:  allowed = attr.rd;
         ACC_STORE: allowed = attr.wr;
         default:   allowed = attr.ex;
      endcase
   end

   always_comb begin
      if (user && !rinfo.user_ok)         exc = EXC_MODE;
      else if (!rinfo.bypass && !hit)     exc = EXC_MISS;
      else if (!rinfo.bypass && !allowed) exc = EXC_PERM;
      else                                exc = EXC_NONE;
   end

   assign cacheable = (exc == EXC_NONE) &&
                      (rinfo.bypass ? rinfo.fixed_cache : attr.cache);

endmodule

// File: rtl/mmu_region_xlate.sv
module mmu_region_xlate
   import mmu_xlate_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PID_W     = 8,
   parameter int ENTRIES   = 16,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES),
   localparam int DIRECT_W = VA_W - 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic             req_user,
   input  logic [PID_W-1:0] req_pid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [PID_W-1:0] wr_pid,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [PFN_W-1:0] wr_pfn,
   input  logic             wr_rd,
   input  logic             wr_wr,
   input  logic             wr_ex,
   input  logic             wr_cache,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_cacheable,
   output logic [1:0]       rsp_exc
);

   if (VA_W < 16 || PA_W < 16) begin : g_bad_width
      $error("address widths must be at least 16 bits");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= DIRECT_W) begin : g_bad_page
      $error("page offset must be narrower than the direct-mapped field");
   end
   if (PA_W < DIRECT_W) begin : g_bad_direct
      $error("physical space too narrow for direct-mapped regions");
   end
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("table depth must be a power of two, at least 2");
   end

   region_info_t     rinfo;
   logic             hit;
   logic [PFN_W-1:0] pfn;
   page_attr_t       attr;
   page_attr_t       wr_attr;
   exc_code_e        exc;
   logic             cache_nx;
   logic [PA_W-1:0]  pa_nx;

   assign wr_attr = '{rd: wr_rd, wr: wr_wr, ex: wr_ex, cache: wr_cache};

   mmu_region_decode u_decode (
      .top_bits (req_vaddr[VA_W-1 -: 3]),
      .info     (rinfo)
   );

   mmu_tlb_cam #(
      .ENTRIES (ENTRIES),
      .PID_W   (PID_W),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W)
   ) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_valid (wr_valid),
      .wr_pid   (wr_pid),
      .wr_vpn   (wr_vpn),
      .wr_pfn   (wr_pfn),
      .wr_attr  (wr_attr),
      .lk_pid   (req_pid),
      .lk_vpn   (req_vaddr[VA_W-1:PAGE_BITS]),
      .lk_hit   (hit),
      .lk_pfn   (pfn),
      .lk_attr  (attr)
   );

   mmu_access_check u_check (
      .rinfo     (rinfo),
      .user      (req_user),
      .kind      (req_kind),
      .hit       (hit),
      .attr      (attr),
      .exc       (exc),
      .cacheable (cache_nx)
   );

   always_comb begin
      if (exc != EXC_NONE)   pa_nx = '0;
      else if (rinfo.bypass) pa_nx = {{(PA_W-DIRECT_W){1'b0}}, req_vaddr[DIRECT_W-1:0]};
      else                   pa_nx = {pfn, req_vaddr[PAGE_BITS-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_cacheable <= 1'b0;
         rsp_exc       <= EXC_NONE;
      end else begin
         rsp_valid     <= req_valid;
         rsp_paddr     <= req_valid ? pa_nx : '0;
         rsp_cacheable <= req_valid && cache_nx;
         rsp_exc       <= req_valid ? exc : EXC_NONE;
      end
   end

endmodule

// File: rtl/mmu_region_xlate_chk.sv
module mmu_region_xlate_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_user,
   input logic            rsp_valid,
   input logic [PA_W-1:0] rsp_paddr,
   input logic            rsp_cacheable,
   input logic [1:0]      rsp_exc
);

   localparam int DW = VA_W - 3;

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rsp_valid == $past(req_valid));

   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_exc == 2'd0 && rsp_paddr == '0 && !rsp_cacheable));

   p_user_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_user && req_vaddr[VA_W-1] |=> rsp_exc == 2'd1);

   p_user_region_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_vaddr[VA_W-1] |=> rsp_exc != 2'd1);

   p_io_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_user && req_vaddr[VA_W-1 -: 3] == 3'b111 |=>
         (rsp_exc == 2'd0 && !rsp_cacheable &&
          rsp_paddr == {{(PA_W-DW){1'b0}}, $past(req_vaddr[DW-1:0])}));

   p_kern_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_user && req_vaddr[VA_W-1 -: 3] == 3'b110 |=>
         (rsp_exc == 2'd0 && rsp_cacheable &&
          rsp_paddr == {{(PA_W-DW){1'b0}}, $past(req_vaddr[DW-1:0])}));

   p_exc_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_exc != 2'd0 |-> (rsp_paddr == '0 && !rsp_cacheable));

   p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !(req_vaddr[VA_W-1] && req_vaddr[VA_W-2]) |=>
         (rsp_exc != 2'd0 || rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));

endmodule

bind mmu_region_xlate mmu_region_xlate_chk #(
   .VA_W      (VA_W),
   .PA_W      (PA_W),
   .PAGE_BITS (PAGE_BITS)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_vaddr     (req_vaddr),
   .req_user      (req_user),
   .rsp_valid     (rsp_valid),
   .rsp_paddr     (rsp_paddr),
   .rsp_cacheable (rsp_cacheable),
   .rsp_exc       (rsp_exc)
);

// File: tb/mmu_region_xlate_bench.sv
module mmu_region_xlate_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_user = 1'b0;
   logic [7:0]  req_pid = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic        wr_valid = 1'b0;
   logic [7:0]  wr_pid = '0;
   logic [19:0] wr_vpn = '0;
   logic [19:0] wr_pfn = '0;
   logic        wr_rd = 1'b0, wr_wr = 1'b0, wr_ex = 1'b0, wr_cache = 1'b0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_cacheable;
   logic [1:0]  rsp_exc;

   int n_chk = 0;
   int n_bad = 0;

   logic        t_v   [N];
   logic [7:0]  t_pid [N];
   logic [19:0] t_vpn [N];
   logic [19:0] t_pfn [N];
   logic [3:0]  t_prm [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_region_xlate u_mmu_region_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
      .req_user(req_user), .req_pid(req_pid),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_pid(wr_pid),
      .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_rd(wr_rd), .wr_wr(wr_wr),
      .wr_ex(wr_ex), .wr_cache(wr_cache),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_cacheable(rsp_cacheable), .rsp_exc(rsp_exc)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // prm bits: 0 read, 1 write, 2 execute, 3 cacheable
   task automatic model(input logic [31:0] va, input logic [1:0] kind, input logic usr,
                        input logic [7:0] pid, output logic [1:0] e,
                        output logic [31:0] pa, output logic c);
      int hit_i;
      logic ok;
      e = 2'd0; pa = '0; c = 1'b0; hit_i = -1;
      if (usr && va[31]) e = 2'd1;
      else if (va[31:29] == 3'b111) begin pa = {3'b0, va[28:0]}; c = 1'b0; end
      else if (va[31:29] == 3'b110) begin pa = {3'b0, va[28:0]}; c = 1'b1; end
      else begin
         for (int i = N - 1; i >= 0; i--)
            if (t_v[i] && t_pid[i] == pid && t_vpn[i] == va[31:12]) hit_i = i;
         if (hit_i < 0) e = 2'd2;
         else begin
            ok = (kind == 2'd0) ? t_prm[hit_i][0] :
                 (kind == 2'd1) ? t_prm[hit_i][1] : t_prm[hit_i][2];
            if (!ok) e = 2'd3;
            else begin pa = {t_pfn[hit_i], va[11:0]}; c = t_prm[hit_i][3]; end
         end
      end
      if (e != 2'd0) begin pa = '0; c = 1'b0; end
   endtask

   task automatic write_entry(input int idx, input logic v, input logic [7:0] pid,
                              input logic [19:0] vpn, input logic [19:0] pfn,
                              input logic [3:0] prm);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_pid = pid;
      wr_vpn = vpn; wr_pfn = pfn;
      wr_rd = prm[0]; wr_wr = prm[1]; wr_ex = prm[2]; wr_cache = prm[3];
      @(negedge clk);
      wr_en = 1'b0;
      t_v[idx] = v; t_pid[idx] = pid; t_vpn[idx] = vpn; t_pfn[idx] = pfn; t_prm[idx] = prm;
   endtask

   task automatic xlate(input string req, input logic [31:0] va, input logic [1:0] kind,
                        input logic usr, input logic [7:0] pid);
      logic [1:0]  e;
      logic [31:0] pa;
      logic        c;
      model(va, kind, usr, pid, e, pa, c);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr; req_pid = pid;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, 32'(rsp_valid), 32'd1);
      check({req, " exc"}, 32'(rsp_exc), 32'(e));
      check({req, " paddr"}, rsp_paddr, pa);
      check({req, " cache"}, 32'(rsp_cacheable), 32'(c));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         t_v[i] = 1'b0; t_pid[i] = '0; t_vpn[i] = '0; t_pfn[i] = '0; t_prm[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      xlate("R1 empty table user", 32'h0000_0123, 2'd0, 1'b0, 8'h00);
      xlate("R1 empty table kmap", 32'h8000_0456, 2'd2, 1'b0, 8'h00);

      // R2: idle outputs after a response
      @(negedge clk);
      check("R2 idle valid", 32'(rsp_valid), 32'd0);
      check("R2 idle paddr", rsp_paddr, 32'd0);
      check("R2 idle exc", 32'(rsp_exc), 32'd0);

      // fill the table: odd entries sit in the supervisor-mapped region (R12)
      for (int i = 0; i < N; i++)
         write_entry(i, (i != 15), 8'(i * 3 + 1),
                     20'((i % 2) ? 20'h80000 : 20'h0) | 20'(i * 37 + 5),
                     20'hA0000 + 20'(i * 19), 4'(i));

      // R6 R7 R8 R5 R9 R12: sweep every entry, kind, mode, tag match/mismatch
      for (int i = 0; i < N; i++)
         for (int k = 0; k < 4; k++)
            for (int u = 0; u < 2; u++)
               for (int m = 0; m < 2; m++)
                  xlate("R6/R7/R8/R5/R9/R12 sweep",
                        {t_vpn[i], 12'(i * 101 + k * 7)}, 2'(k), u[0],
                        m ? (t_pid[i] ^ 8'h80) : t_pid[i]);

      // R3 R4 R5: direct regions in both modes, all kinds
      for (int a = 0; a < 8; a++)
         for (int k = 0; k < 4; k++)
            for (int u = 0; u < 2; u++)
               xlate("R3/R4/R5 direct",
                     {2'b11, a[0], 29'(a * 32'h0456_789B + 32'h1F)}, 2'(k), u[0], 8'h5A);

      // R11: two entries with the same tag and page, lowest index wins
      write_entry(2, 1'b1, 8'h77, 20'h00ABC, 20'h11111, 4'b1111);
      write_entry(9, 1'b1, 8'h77, 20'h00ABC, 20'h22222, 4'b0111);
      xlate("R11 lowest index", 32'h00AB_C321, 2'd1, 1'b1, 8'h77);
      check("R11 frame from entry 2", {12'h0, rsp_paddr[31:12]}, 32'h11111);
      write_entry(2, 1'b0, 8'h77, 20'h00ABC, 20'h11111, 4'b1111);
      xlate("R11 R6 invalidated low entry", 32'h00AB_C321, 2'd1, 1'b1, 8'h77);
      check("R6 frame from entry 9", {12'h0, rsp_paddr[31:12]}, 32'h22222);

      // R10: request in the same cycle as a write sees old contents
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {t_vpn[0], 12'h0AA}; req_kind = 2'd0;
      req_user = 1'b0; req_pid = t_pid[0];
      wr_en = 1'b1; wr_idx = 4'd0; wr_valid = 1'b1; wr_pid = t_pid[0]; wr_vpn = t_vpn[0];
      wr_pfn = 20'h33333; wr_rd = 1'b1; wr_wr = 1'b1; wr_ex = 1'b1; wr_cache = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; wr_en = 1'b0;
      // entry 0 had no read permission before the write
      check("R10 old contents exc", 32'(rsp_exc), 32'd3);
      t_pfn[0] = 20'h33333; t_prm[0] = 4'b1111;
      xlate("R10 new contents", {t_vpn[0], 12'h0AA}, 2'd0, 1'b0, t_pid[0]);
      check("R10 new frame", {12'h0, rsp_paddr[31:12]}, 32'h33333);

      @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule